// File: doc/BRIEF.md
# Dual Converter Start Scheduler

This block decides when a master and a slave analog-to-digital converter begin a conversion. It receives shared trigger events for a regular group and an injected group and a 4-bit dual-mode code. From these it drives separate regular and injected start strobes for each converter. The mode code belongs to the master side, and the slave only follows the schedule the block computes. Modes cover independent operation, same-cycle starts, staggered starts and injected triggers that alternate between the two converters. Several codes pair a regular behaviour with a different injected behaviour.

Every start strobe is a registered single-cycle pulse. It appears in the cycle after the clock edge that samples the trigger. Staggered starts come from one shared countdown. While that countdown runs, further regular triggers are refused and recorded. Two configurations would let the sampling windows of the converters overlap. The block flags both of them and withholds the regular starts they would cause. Each converter returns a done pulse, and `busy` stays high until all issued conversions are finished and no staggered start is still pending.

Top module: `dual_start_sched`

## Requirements
- R1: After reset every start strobe, `busy`, `overrun` and `cfg_err` are low, and the alternate-trigger target is the master.
- R2: With code 0, or any unused code 10 to 15, a regular trigger pulses only `mst_reg_start` and an injected trigger pulses only `mst_inj_start`. Either pulse appears in the cycle after the trigger is sampled.
- R3: With codes 1, 2 and 6, a regular trigger pulses `mst_reg_start` and `slv_reg_start` in the same cycle, one cycle after the trigger.
- R4: With codes 1, 3, 4 and 5, an injected trigger pulses `mst_inj_start` and `slv_inj_start` in the same cycle, one cycle after the trigger.
- R5: With codes 3 and 7, a regular trigger pulses `mst_reg_start` one cycle after the trigger and `slv_reg_start` FAST_GAP (7) cycles after that master pulse.
- R6: With codes 4 and 8, a regular trigger gives three pulses. The first is `mst_reg_start` one cycle after the trigger. Next comes `slv_reg_start` SLOW_GAP (14) cycles later. Last comes `mst_reg_start` again SLOW_GAP cycles after the slave pulse.
- R7: With codes 2 and 9, successive injected triggers pulse `mst_inj_start` and `slv_inj_start` in turn, and the first goes to the master.
- R8: Any change of `mode_code` points the alternate-trigger target back at the master.
- R9: `cfg_err` is high while the code is 3 or 7 and `smp_cycles` exceeds FAST_GAP, and also while the code is 4 or 8 and `grp_len` exceeds 1. While `cfg_err` is high, regular triggers produce no start pulse.
- R10: A regular trigger that arrives while a staggered schedule is still pending produces no pulse. It sets `overrun`, which then stays high until reset.
- R11: `busy` is high in every cycle with a start pulse. It returns low once each started converter has returned its done pulse and no staggered start is pending.
- R12: Where a group has no dual behaviour, its trigger starts only the master. This applies to regular triggers under codes 5 and 9 and to injected triggers under codes 6, 7 and 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_code | input | 4 | Dual-mode code, 0 to 9 (see requirements) |
| reg_trig | input | 1 | Regular group trigger pulse |
| inj_trig | input | 1 | Injected group trigger pulse |
| smp_cycles | input | SMP_W | Sample time of the shared channel, in clocks |
| grp_len | input | GRP_W | Number of channels in the regular group |
| mst_done | input | 1 | Master conversion finished |
| slv_done | input | 1 | Slave conversion finished |
| mst_reg_start | output | 1 | Master regular start strobe |
| slv_reg_start | output | 1 | Slave regular start strobe |
| mst_inj_start | output | 1 | Master injected start strobe |
| slv_inj_start | output | 1 | Slave injected start strobe |
| busy | output | 1 | Conversions outstanding or schedule pending |
| cfg_err | output | 1 | Staggered mode configured so that sampling would overlap |
| overrun | output | 1 | Sticky: a regular trigger was dropped |

## Verification
The bench builds the block with its defaults, FAST_GAP = 7 and SLOW_GAP = 14. It therefore checks the exact 7- and 28-cycle stagger windows and the sample-time limit at its boundary, using 7 (allowed) and 8 (flagged). With SMP_W = 8 and GRP_W = 5, the bench can set a group length of 2 to trip the single-channel rule, and can send a second trigger into the pending window. The converter stubs reply with done pulses a few cycles after each start, so `busy` can be seen both rising and falling.

// File: rtl/dual_start_sched.sv
module dual_start_sched #(
  parameter int FAST_GAP = 7,
  parameter int SLOW_GAP = 14,
  parameter int SMP_W    = 8,
  parameter int GRP_W    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       mode_code,
  input  logic             reg_trig,
  input  logic             inj_trig,
  input  logic [SMP_W-1:0] smp_cycles,
  input  logic [GRP_W-1:0] grp_len,
  input  logic             mst_done,
  input  logic             slv_done,
  output logic             mst_reg_start,
  output logic             slv_reg_start,
  output logic             mst_inj_start,
  output logic             slv_inj_start,
  output logic             busy,
  output logic             cfg_err,
  output logic             overrun
);

  localparam int MAX_GAP = (FAST_GAP > SLOW_GAP) ? FAST_GAP : SLOW_GAP;
  localparam int CNT_W   = $clog2(MAX_GAP + 1);

  typedef enum logic [1:0] {PH_IDLE, PH_SLV, PH_MST2} phase_t;

  phase_t             phase;
  logic [CNT_W-1:0]   cnt;
  logic [3:0]         mode_q;
  logic               tgl, m_act, s_act;
  logic               mr_n, sr_n, mi_n, si_n;

  wire mode_chg = mode_code != mode_q;
  wire is_rsim  = mode_code == 4'd1 || mode_code == 4'd2 || mode_code == 4'd6;
  wire is_isim  = mode_code == 4'd1 || mode_code == 4'd3 ||
                  mode_code == 4'd4 || mode_code == 4'd5;
  wire is_fast  = mode_code == 4'd3 || mode_code == 4'd7;
  wire is_slow  = mode_code == 4'd4 || mode_code == 4'd8;
  wire is_alt   = mode_code == 4'd2 || mode_code == 4'd9;

  assign cfg_err = (is_fast && smp_cycles > SMP_W'(FAST_GAP)) ||
                   (is_slow && grp_len > GRP_W'(1));

  wire pend    = phase != PH_IDLE && !mode_chg;
  wire fire    = pend && cnt == '0;
  wire acc_reg = reg_trig && !cfg_err && !pend;
  wire tgl_eff = mode_chg ? 1'b0 : tgl;

  always_comb begin
    mr_n = acc_reg || (fire && phase == PH_MST2);
    sr_n = (acc_reg && is_rsim) || (fire && phase == PH_SLV);
    mi_n = inj_trig && !(is_alt && tgl_eff);
    si_n = inj_trig && (is_isim || (is_alt && tgl_eff));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase         <= PH_IDLE;
      cnt           <= '0;
      mode_q        <= mode_code;
      tgl           <= 1'b0;
      m_act         <= 1'b0;
      s_act         <= 1'b0;
      overrun       <= 1'b0;
      mst_reg_start <= 1'b0;
      slv_reg_start <= 1'b0;
      mst_inj_start <= 1'b0;
      slv_inj_start <= 1'b0;
    end else begin
      mode_q        <= mode_code;
      mst_reg_start <= mr_n;
      slv_reg_start <= sr_n;
      mst_inj_start <= mi_n;
      slv_inj_start <= si_n;
      tgl           <= (is_alt && inj_trig) ? ~tgl_eff : tgl_eff;
      overrun       <= overrun | (reg_trig && pend);
      m_act         <= (mr_n || mi_n) ? 1'b1 : (mst_done ? 1'b0 : m_act);
      s_act         <= (sr_n || si_n) ? 1'b1 : (slv_done ? 1'b0 : s_act);
      if (acc_reg && (is_fast || is_slow)) begin
        phase <= PH_SLV;
        cnt   <= is_fast ? CNT_W'(FAST_GAP - 1) : CNT_W'(SLOW_GAP - 1);
      end else if (pend) begin
        if (cnt == '0) begin
          if (phase == PH_SLV && is_slow) begin
            phase <= PH_MST2;
            cnt   <= CNT_W'(SLOW_GAP - 1);
          end else begin
            phase <= PH_IDLE;
          end
        end else begin
          cnt <= cnt - 1'b1;
        end
      end else begin
        phase <= PH_IDLE;
      end
    end
  end

  assign busy = m_act || s_act || phase != PH_IDLE;

endmodule

// File: rtl/dual_start_sched_chk.sv
module dual_start_sched_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] mode_code,
  input logic       mst_reg_start,
  input logic       slv_reg_start,
  input logic       mst_inj_start,
  input logic       slv_inj_start,
  input logic       busy,
  input logic       overrun
);

  // R2
  indep_slave_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !($past(mode_code) inside {4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7, 4'd8, 4'd9})
      |-> (!slv_reg_start && !slv_inj_start));

  // R3
  reg_sim_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mst_reg_start && ($past(mode_code) inside {4'd1, 4'd2, 4'd6})) |-> slv_reg_start);

  // R4
  inj_sim_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mst_inj_start && ($past(mode_code) inside {4'd1, 4'd3, 4'd4, 4'd5})) |-> slv_inj_start);

  // R7
  alt_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_code) inside {4'd2, 4'd9}) |-> !(mst_inj_start && slv_inj_start));

  // R10
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

  // R11
  busy_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mst_reg_start || slv_reg_start || mst_inj_start || slv_inj_start) |-> busy);

endmodule

bind dual_start_sched dual_start_sched_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .mode_code     (mode_code),
  .mst_reg_start (mst_reg_start),
  .slv_reg_start (slv_reg_start),
  .mst_inj_start (mst_inj_start),
  .slv_inj_start (slv_inj_start),
  .busy          (busy),
  .overrun       (overrun)
);

// File: tb/dual_start_sched_tb.sv
module dual_start_sched_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] mode_code = 4'd0;
  logic       reg_trig = 1'b0, inj_trig = 1'b0;
  logic [7:0] smp_cycles = 8'd3;
  logic [4:0] grp_len = 5'd1;
  logic       mst_done, slv_done;
  logic       mst_reg_start, slv_reg_start, mst_inj_start, slv_inj_start;
  logic       busy, cfg_err, overrun;

  int checks = 0, errors = 0, cyc = 0, pulses = 0;
  string cur_req = "R1";

  typedef struct {
    int         at;
    logic [3:0] v;
    string      req;
  } exp_t;
  exp_t exp_q[$];

  always #10 clk = ~clk;

  dual_start_sched u_dut (
    .clk(clk), .rst_n(rst_n), .mode_code(mode_code), .reg_trig(reg_trig),
    .inj_trig(inj_trig), .smp_cycles(smp_cycles), .grp_len(grp_len),
    .mst_done(mst_done), .slv_done(slv_done), .mst_reg_start(mst_reg_start),
    .slv_reg_start(slv_reg_start), .mst_inj_start(mst_inj_start),
    .slv_inj_start(slv_inj_start), .busy(busy), .cfg_err(cfg_err),
    .overrun(overrun)
  );

  int mcnt = 0, scnt = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      mcnt <= 0;
      scnt <= 0;
    end else begin
      if (mst_reg_start || mst_inj_start) mcnt <= 5;
      else if (mcnt != 0) mcnt <= mcnt - 1;
      if (slv_reg_start || slv_inj_start) scnt <= 5;
      else if (scnt != 0) scnt <= scnt - 1;
    end
  end
  assign mst_done = (mcnt == 1);
  assign slv_done = (scnt == 1);

  always @(negedge clk) begin
    if (rst_n) begin
      logic [3:0] obs, ev;
      string tag;
      obs = {mst_reg_start, slv_reg_start, mst_inj_start, slv_inj_start};
      ev  = 4'b0;
      tag = cur_req;
      while (exp_q.size() > 0 && exp_q[0].at <= cyc) begin
        exp_t e;
        e = exp_q.pop_front();
        ev = ev | e.v;
        tag = e.req;
      end
      for (int b = 0; b < 4; b++) if (obs[b]) pulses++;
      if (obs != 4'b0 || ev != 4'b0) begin
        checks++;
        if (obs != ev) begin
          errors++;
          $display("FAIL %s cycle %0d starts {mr,sr,mi,si} actual %b expected %b",
                   tag, cyc, obs, ev);
        end
      end
    end
  end

  task automatic push(input int dc, input logic [3:0] v, input string req);
    exp_t e;
    e.at = cyc + dc;
    e.v = v;
    e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic go(input logic r, input logic i);
    reg_trig = r;
    inj_trig = i;
    @(negedge clk);
    reg_trig = 1'b0;
    inj_trig = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_mode(input logic [3:0] m);
    @(negedge clk);
    mode_code = m;
    idle(2);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, expv);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int p0;
    idle(5);
    rst_n = 1'b1;
    idle(2);
    // R1
    chk({mst_reg_start, slv_reg_start, mst_inj_start, slv_inj_start} == 4'b0, "R1 starts", 0, 0);
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(cfg_err == 1'b0, "R1 cfg_err", cfg_err, 0);
    chk(overrun == 1'b0, "R1 overrun", overrun, 0);

    // R2: independent and an unused code
    cur_req = "R2";
    @(negedge clk); push(1, 4'b1000, "R2"); go(1, 0); idle(10);
    push(1, 4'b0010, "R2"); go(0, 1); idle(10);
    set_mode(4'd12);
    push(1, 4'b1000, "R2"); go(1, 0); idle(10);
    push(1, 4'b0010, "R2"); go(0, 1); idle(10);

    // R3 with R12 on the injected side
    cur_req = "R3";
    set_mode(4'd6);
    push(1, 4'b1100, "R3"); go(1, 0); idle(10);
    push(1, 4'b0010, "R12"); go(0, 1); idle(10);

    // R3 and R4 together
    set_mode(4'd1);
    push(1, 4'b1111, "R3 R4"); go(1, 1); idle(10);

    // R4 with R12 on the regular side
    cur_req = "R4";
    set_mode(4'd5);
    push(1, 4'b0011, "R4"); go(0, 1); idle(10);
    push(1, 4'b1000, "R12"); go(1, 0); idle(10);

    // R5 fast stagger, R11 busy
    cur_req = "R5";
    set_mode(4'd7);
    push(1, 4'b1000, "R5"); push(8, 4'b0100, "R5"); go(1, 0);
    idle(2);
    chk(busy == 1'b1, "R11 busy during schedule", busy, 1);
    idle(40);
    chk(busy == 1'b0, "R11 busy after done", busy, 0);
    push(1, 4'b0010, "R12"); go(0, 1); idle(10);

    // R6 slow stagger, R10 overrun
    cur_req = "R6";
    set_mode(4'd8);
    chk(overrun == 1'b0, "R10 overrun before", overrun, 0);
    push(1, 4'b1000, "R6"); push(15, 4'b0100, "R6"); push(29, 4'b1000, "R6"); go(1, 0);
    idle(3);
    go(1, 0);
    idle(2);
    chk(overrun == 1'b1, "R10 overrun set", overrun, 1);
    idle(40);
    chk(overrun == 1'b1, "R10 overrun held", overrun, 1);

    // R7 alternation
    cur_req = "R7";
    set_mode(4'd9);
    push(1, 4'b0010, "R7"); go(0, 1); idle(10);
    push(1, 4'b0001, "R7"); go(0, 1); idle(10);
    push(1, 4'b0010, "R7"); go(0, 1); idle(10);
    push(1, 4'b1000, "R12"); go(1, 0); idle(10);

    // R8 toggle back to master after mode change
    cur_req = "R8";
    set_mode(4'd2);
    push(1, 4'b0010, "R8"); go(0, 1); idle(10);
    push(1, 4'b0001, "R7"); go(0, 1); idle(10);
    push(1, 4'b1100, "R3"); go(1, 0); idle(10);

    // R9 configuration errors
    cur_req = "R9";
    smp_cycles = 8'd8;
    set_mode(4'd7);
    chk(cfg_err == 1'b1, "R9 fast sample 8", cfg_err, 1);
    p0 = pulses;
    go(1, 0); idle(20);
    chk(pulses == p0, "R9 fast suppressed", pulses - p0, 0);
    smp_cycles = 8'd7;
    idle(1);
    chk(cfg_err == 1'b0, "R9 fast sample 7", cfg_err, 0);
    push(1, 4'b1000, "R9"); push(8, 4'b0100, "R9"); go(1, 0); idle(20);
    grp_len = 5'd2;
    set_mode(4'd8);
    chk(cfg_err == 1'b1, "R9 slow group 2", cfg_err, 1);
    p0 = pulses;
    go(1, 0); idle(40);
    chk(pulses == p0, "R9 slow suppressed", pulses - p0, 0);
    set_mode(4'd6);
    chk(cfg_err == 1'b0, "R9 group 2 non-slow", cfg_err, 0);
    grp_len = 5'd1;
    set_mode(4'd8);
    chk(cfg_err == 1'b0, "R9 slow group 1", cfg_err, 0);
    idle(20);

    chk(exp_q.size() == 0, "R5 R6 all expected starts seen", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule